// File: doc/BRIEF.md
# Iterative SM3 Compression Round Engine

This block performs one SM3 compression iteration over a single 512-bit message block. The caller loads a 256-bit chaining value and raises a start strobe. The engine then runs one round per clock over 64 clocks and updates eight 32-bit working lanes on each clock. During this run it takes the per-round word pair from an external message-expansion unit. The engine publishes the index of the round it is executing, so that the expansion unit can present the matching plain word and the mixed word (plain xor the word four positions later) in the same cycle.

After the last round, the engine xors the working lanes with the chaining value it loaded and registers the result as the next chaining value. A single-cycle completion strobe marks the result. The result then stays on the output until the next completion. While a run is in progress, the engine ignores new start requests. In the cycle of the completion strobe the engine is already idle, so a following block can be started with no gap.

Top module: `sm3c_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy_o` and `done_o` are both 0.
- R2: A `start_i` seen high at a rising edge while the engine is idle loads `v_in`, where lane A is bits 255:224 and lane H is bits 31:0. After that edge `busy_o` is 1 and `rnd_o` is 0.
- R3: While busy, `rnd_o` advances by one per clock from 0 to 63. `busy_o` stays high for exactly 64 cycles.
- R4: `done_o` is high for exactly one cycle, the cycle after round 63. `busy_o` is 0 in that cycle. `v_out` is valid in that cycle, 64 cycles after the accepting edge.
- R5: `v_out` equals the final lanes A..H (A in bits 255:224) xored with the loaded chaining value. For the padded block "abc" (first word 0x61626380, last word 0x00000018, zeros between) with the standard initial value, the result is 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.
- R6: Rounds 0 to 15 use the three-input xor for both Boolean functions and the constant 0x79CC4519. Rounds 16 to 63 use majority on A,B,C, choice (E selects F, else G) on E,F,G, and the constant 0x7A879D8A.
- R7: The round constant is rotated left by the round index modulo 32.
- R8: A `start_i` raised while busy, with a different `v_in`, changes neither the round sequence, the completion time nor the result.
- R9: A start in the same cycle as `done_o` is accepted. The new run begins at that edge, and the old result is still reported correctly.
- R10: `v_out` changes only on the edge where `done_o` rises, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a compression with `v_in` |
| v_in | input | 256 | Chaining value in, lane A in the top word |
| w_i | input | 32 | Plain expanded word for round `rnd_o` |
| wp_i | input | 32 | Mixed expanded word for round `rnd_o` |
| busy_o | output | 1 | Rounds in progress |
| rnd_o | output | 6 | Index of the round executing this cycle |
| done_o | output | 1 | One-cycle strobe: `v_out` is new |
| v_out | output | 256 | Next chaining value |

## Verification
Two events can fall in one cycle: the completion strobe of one block and the acceptance of the next start. The bench provokes this by waiting for `done_o` and raising `start_i` with a fresh block in that same cycle. The scoreboard must then pop the old block's expected value at that strobe and the new block's value 64 cycles later. The bench also checks that `busy_o` and `rnd_o` = 0 follow the accepting edge directly. A second overlap comes from start pulses held during a run; those must leave the completion time and the result unchanged.

// File: rtl/sm3c_pkg.sv
package sm3c_pkg;

    localparam int WORD_W   = 32;
    localparam int LANES    = 8;
    localparam int STATE_W  = WORD_W * LANES;
    localparam int ROUNDS   = 64;
    localparam int RND_W    = $clog2(ROUNDS);
    localparam int SPLIT    = 16;
    localparam int ROT_W    = $clog2(WORD_W);

    localparam logic [WORD_W-1:0] K_EARLY = 32'h79CC4519;
    localparam logic [WORD_W-1:0] K_LATE  = 32'h7A879D8A;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } lanes_t;

    typedef enum logic {PH_IDLE, PH_RUN} phase_t;

    function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] n);
        return (x << n) | (x >> (7'd32 - {2'b00, n}));
    endfunction

    function automatic word_t perm0(input word_t x);
        return x ^ rotl(x, 5'd9) ^ rotl(x, 5'd17);
    endfunction

    function automatic word_t mix_abc(input logic late, input word_t x, input word_t y, input word_t z);
        return late ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
    endfunction

    function automatic word_t mix_efg(input logic late, input word_t x, input word_t y, input word_t z);
        return late ? ((x & y) | (~x & z)) : (x ^ y ^ z);
    endfunction

endpackage

// File: rtl/sm3c_round.sv
module sm3c_round
    import sm3c_pkg::*;
(
    input  lanes_t cur,
    input  rnd_t   rnd,
    input  word_t  w,
    input  word_t  wp,
    output lanes_t nxt
);
    logic  late;
    word_t kc, krot, a12, ss1, ss2, tt1, tt2;

    always_comb begin
        late = (rnd >= RND_W'(SPLIT));
        kc   = late ? K_LATE : K_EARLY;
        krot = rotl(kc, rnd[ROT_W-1:0]);
        a12  = rotl(cur.a, 5'd12);
        ss1  = rotl(a12 + cur.e + krot, 5'd7);
        ss2  = ss1 ^ a12;
        tt1  = mix_abc(late, cur.a, cur.b, cur.c) + cur.d + ss2 + wp;
        tt2  = mix_efg(late, cur.e, cur.f, cur.g) + cur.h + ss1 + w;

        nxt.a = tt1;
        nxt.b = cur.a;
        nxt.c = rotl(cur.b, 5'd9);
        nxt.d = cur.c;
        nxt.e = perm0(tt2);
        nxt.f = cur.e;
        nxt.g = rotl(cur.f, 5'd19);
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sm3c_ctrl.sv
module sm3c_ctrl
    import sm3c_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output rnd_t rnd,
    output logic busy,
    output logic done
);
    phase_t phase_q;
    rnd_t   rnd_q;
    logic   done_q;

    always_comb begin
        load = (phase_q == PH_IDLE) && start;
        step = (phase_q == PH_RUN);
        last = step && (rnd_q == RND_W'(ROUNDS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                phase_q <= PH_RUN;
                rnd_q   <= '0;
            end else if (last) begin
                phase_q <= PH_IDLE;
                rnd_q   <= '0;
            end else if (step) begin
                rnd_q <= rnd_q + RND_W'(1);
            end
        end
    end

    assign rnd  = rnd_q;
    assign busy = step;
    assign done = done_q;
endmodule

// File: rtl/sm3c_lanes.sv
module sm3c_lanes
    import sm3c_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  logic   last,
    input  lanes_t seed_in,
    input  lanes_t nxt,
    output lanes_t cur,
    output lanes_t result
);
    lanes_t cur_q, seed_q, res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            seed_q <= '0;
            res_q  <= '0;
        end else begin
            if (load) begin
                cur_q  <= seed_in;
                seed_q <= seed_in;
            end else if (step) begin
                cur_q <= nxt;
            end
            if (last) begin
                res_q <= nxt ^ seed_q;
            end
        end
    end

    assign cur    = cur_q;
    assign result = res_q;
endmodule

// File: rtl/sm3c_engine.sv
module sm3c_engine
    import sm3c_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [255:0] v_in,
    input  logic [31:0]  w_i,
    input  logic [31:0]  wp_i,
    output logic         busy_o,
    output logic [5:0]   rnd_o,
    output logic         done_o,
    output logic [255:0] v_out
);
    logic   load, step, last;
    rnd_t   rnd;
    lanes_t cur, nxt, result;

    sm3c_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .step  (step),
        .last  (last),
        .rnd   (rnd),
        .busy  (busy_o),
        .done  (done_o)
    );

    sm3c_round u_round (
        .cur (cur),
        .rnd (rnd),
        .w   (w_i),
        .wp  (wp_i),
        .nxt (nxt)
    );

    sm3c_lanes u_lanes (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step),
        .last    (last),
        .seed_in (lanes_t'(v_in)),
        .nxt     (nxt),
        .cur     (cur),
        .result  (result)
    );

    assign rnd_o = rnd;
    assign v_out = result;
endmodule

// File: rtl/sm3c_engine_chk.sv
module sm3c_engine_chk (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy_o,
    input logic [5:0]   rnd_o,
    input logic         done_o,
    input logic [255:0] v_out
);
    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o));

    // R2
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && rnd_o == 6'd0));

    // R3
    a_r3_round_advance: assert property (@(posedge clk) disable iff (rst)
        (busy_o && rnd_o != 6'd63) |=> (busy_o && rnd_o == 6'($past(rnd_o) + 6'd1)));

    // R4
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (busy_o && rnd_o == 6'd63) |=> (done_o && !busy_o));

    // R4
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o && rnd_o != 6'd63) |=> (rnd_o != 6'd0));

    // R10
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(done_o) |-> $stable(v_out));
endmodule

bind sm3c_engine sm3c_engine_chk u_chk (.*);

// File: tb/sm3c_engine_bench.sv
module sm3c_engine_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [255:0] v_in = '0;
    logic [31:0]  w_i, wp_i;
    logic         busy_o;
    logic [5:0]   rnd_o;
    logic         done_o;
    logic [255:0] v_out;

    logic [31:0] cw  [0:63];
    logic [31:0] cwp [0:63];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_acc = 0;
    logic [255:0] last_exp = '0;

    logic [255:0] exp_q [$];
    string        tag_q [$];

    localparam logic [255:0] IV =
        256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
    localparam logic [255:0] ABC_HASH =
        256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;
    localparam logic [511:0] ABC_BLK = {32'h61626380, 448'h0, 32'h00000018};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign w_i  = cw[rnd_o];
    assign wp_i = cwp[rnd_o];

    sm3c_engine u_sm3c_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .v_in(v_in),
        .w_i(w_i), .wp_i(wp_i), .busy_o(busy_o), .rnd_o(rnd_o),
        .done_o(done_o), .v_out(v_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        int k;
        k = n % 32;
        if (k == 0) return x;
        return (x << k) | (x >> (32 - k));
    endfunction

    task automatic expand(input logic [511:0] blk);
        logic [31:0] x [0:67];
        logic [31:0] s;
        for (int j = 0; j < 16; j++) x[j] = blk[511 - 32*j -: 32];
        for (int j = 16; j < 68; j++) begin
            s = x[j-16] ^ x[j-9] ^ rl(x[j-3], 15);
            x[j] = (s ^ rl(s, 15) ^ rl(s, 23)) ^ rl(x[j-13], 7) ^ x[j-6];
        end
        for (int j = 0; j < 64; j++) begin
            cw[j]  = x[j];
            cwp[j] = x[j] ^ x[j+4];
        end
    endtask

    // Spec model of one compression over the words in cw/cwp
    function automatic logic [255:0] model(input logic [255:0] v);
        logic [31:0] a, b, c, d, e, f, g, h, k, r12, s1, s2, f1, g1, t1, t2;
        {a, b, c, d, e, f, g, h} = v;
        for (int j = 0; j < 64; j++) begin
            k   = (j < 16) ? 32'h79CC4519 : 32'h7A879D8A;
            r12 = rl(a, 12);
            s1  = rl(r12 + e + rl(k, j), 7);
            s2  = s1 ^ r12;
            f1  = (j < 16) ? (a ^ b ^ c) : ((a & b) | (a & c) | (b & c));
            g1  = (j < 16) ? (e ^ f ^ g) : ((e & f) | (~e & g));
            t1  = f1 + d + s2 + cwp[j];
            t2  = g1 + h + s1 + cw[j];
            d = c; c = rl(b, 9); b = a; a = t1;
            h = g; g = rl(f, 19); f = e; e = t2 ^ rl(t2, 9) ^ rl(t2, 17);
        end
        return {a, b, c, d, e, f, g, h} ^ v;
    endfunction

    // Driver: call at a negedge; returns at the negedge after the accepting edge
    task automatic run_block(input logic [255:0] v, input logic [511:0] blk,
                             input logic [255:0] expv, input string tag);
        expand(blk);
        v_in = v;
        start_i = 1'b1;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk);
        t_acc = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1 && rnd_o === 6'd0, "R2 busy and round 0 after start",
              {busy_o, rnd_o}, {1'b1, 6'd0});
    endtask

    task automatic wait_done(output int busy_cnt);
        busy_cnt = 0;
        while (done_o !== 1'b1 && busy_cnt < 300) begin
            if (busy_o === 1'b1) busy_cnt++;
            @(negedge clk);
        end
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && done_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", v_out, '0);
            end else begin
                logic [255:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(v_out === e, t, v_out, e);
                check(busy_o === 1'b0 && (cyc - t_acc) == 64, "R4 done timing",
                      256'(cyc - t_acc), 256'd64);
            end
        end
    end

    bit finished = 0;
    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [255:0] rv, ev;
        logic [511:0] rb;
        for (int j = 0; j < 64; j++) begin cw[j] = '0; cwp[j] = '0; end

        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle in reset",
              {busy_o, done_o}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset",
              {busy_o, done_o}, '0);

        // R5: known vector
        expand(ABC_BLK);
        check(model(IV) === ABC_HASH, "R5 model abc", model(IV), ABC_HASH);
        run_block(IV, ABC_BLK, ABC_HASH, "R5 abc hash");
        wait_done(n);
        check(n == 64, "R3 busy length", 256'(n), 256'd64);
        @(negedge clk);
        check(done_o === 1'b0, "R4 done one cycle", {255'd0, done_o}, '0);

        // R6 R7: several patterns over all rounds
        for (int p = 0; p < 5; p++) begin
            rv = {8{$urandom()}};
            for (int q = 0; q < 8; q++) rv[32*q +: 32] = $urandom();
            for (int q = 0; q < 16; q++) rb[32*q +: 32] = $urandom();
            if (p == 0) begin rv = '0; rb = '0; end
            if (p == 1) begin rv = '1; rb = '1; end
            expand(rb);
            ev = model(rv);
            run_block(rv, rb, ev, "R6 R7 pattern result");
            wait_done(n);
            @(negedge clk);
        end

        // R8: start held during a run
        for (int q = 0; q < 16; q++) rb[32*q +: 32] = $urandom();
        rv = {IV[127:0], IV[255:128]};
        expand(rb);
        ev = model(rv);
        run_block(rv, rb, ev, "R8 result with busy start");
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        v_in = ~rv;
        repeat (4) @(negedge clk);
        check(rnd_o === 6'd14, "R8 round unaffected", {250'd0, rnd_o}, 256'd14);
        start_i = 1'b0;
        wait_done(n);

        // R9: start in the done cycle
        for (int q = 0; q < 16; q++) rb[32*q +: 32] = $urandom();
        expand(rb);
        ev = model(IV);
        run_block(IV, rb, ev, "R9 back-to-back second result");
        wait_done(n);
        @(negedge clk);

        // R10: hold
        repeat (6) @(negedge clk);
        check(v_out === last_exp, "R10 result held", v_out, last_exp);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule